// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block sits in the feedback path of a phase-locked loop. It divides a fast input clock by an integer N and marks the end of every N-cycle period with a single-cycle output pulse. A phase detector downstream compares that pulse with a divided reference. N is built from three parts: a small prescaler with modulus P, a swallow count A and a main count B. Together they reach both very small and very large ratios with cheap counters.

A 3-bit mode field selects the prescaler. Three codes give a fixed divide of 1, 2 or 3. Five codes give a dual-modulus prescaler with P of 2, 4, 8, 16 or 32. In dual-modulus mode, the first A prescaler cycles of each period last P+1 input cycles and the remaining ones last P. A bypass control removes the B count, so the period becomes a single prescaler cycle.

The configuration inputs are sampled only at period boundaries and during reset. A setting can therefore be changed at any moment without producing a short or torn period.

Top module: `fbdiv_top`

## Requirements
- R1: Mode codes map as follows: 0 gives fixed /1, 1 gives fixed /2, 7 gives fixed /3, and 2, 3, 4, 5, 6 give dual-modulus with P = 2, 4, 8, 16, 32 respectively.
- R2: In a dual-modulus mode with bypass low and A not above B, the output period is B*P + A input cycles.
- R3: In a fixed-divide mode with bypass low, the period is B*P input cycles, and the A value has no effect.
- R4: With bypass high, the period is P input cycles in every mode, and neither A nor B has any effect.
- R5: The output is high for exactly one input cycle per period, in the last cycle. The first pulse after reset release falls in cycle N, where the first cycle with reset low is cycle 1.
- R6: A configuration change made inside a period leaves that period unchanged and governs the next period.
- R7: The synchronous reset holds the output low and restarts the period, so the first pulse after release again falls in cycle N.
- R8: In dual-modulus mode, an A larger than B acts as A = B, giving a period of B*(P+1).
- R9: A B value of zero acts as B = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Prescaler mode code |
| a_i | input | A_W (6) | Swallow count A |
| b_i | input | B_W (13) | Main count B |
| bbyp_i | input | 1 | Bypass of the B count |
| div_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench measures the position of the first two pulses after reset for every prescaler mode. A wrong mode decode or a misplaced swallow boundary shows up as a period that is off by P or by A.

The corner cases are:
- N of one, where a design that needs two cycles per period would skip pulses.
- A larger than B and B of zero, where an unclamped design would run a much longer period or wrap its counter.
- Bypass with large A and B values, which must be ignored.

A mid-period configuration change checks that the old period completes before the new one starts. A design that reloads immediately would pulse early. A reset issued mid-period checks that a stale count is not carried into the first period after release.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // Prescaler length width: holds up to 33 (P+1 with P = 32)
    localparam int LEN_W = 6;

    typedef enum logic [2:0] {
        MODE_FIX1 = 3'd0,
        MODE_FIX2 = 3'd1,
        MODE_DM2  = 3'd2,
        MODE_DM4  = 3'd3,
        MODE_DM8  = 3'd4,
        MODE_DM16 = 3'd5,
        MODE_DM32 = 3'd6,
        MODE_FIX3 = 3'd7
    } presc_mode_e;

    // Base modulus P for each mode code
    function automatic logic [LEN_W-1:0] mode_base(input logic [2:0] m);
        case (m)
            MODE_FIX1: mode_base = LEN_W'(1);
            MODE_FIX2: mode_base = LEN_W'(2);
            MODE_DM2:  mode_base = LEN_W'(2);
            MODE_DM4:  mode_base = LEN_W'(4);
            MODE_DM8:  mode_base = LEN_W'(8);
            MODE_DM16: mode_base = LEN_W'(16);
            MODE_DM32: mode_base = LEN_W'(32);
            default:   mode_base = LEN_W'(3);
        endcase
    endfunction

    function automatic logic mode_dual(input logic [2:0] m);
        mode_dual = (m >= MODE_DM2) && (m <= MODE_DM32);
    endfunction

endpackage

// File: rtl/fbdiv_presc.sv
module fbdiv_presc #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] load_len,
    output logic             wrap
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    assign wrap = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (rst || wrap) begin
            st_d.cnt = load_len - LEN_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: every prescaler cycle loaded at a wrap has a nonzero length
    p_load_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (load_len != '0));

endmodule

// File: rtl/fbdiv_seq.sv
module fbdiv_seq
    import fbdiv_pkg::*;
#(
    parameter int A_W   = 6,
    parameter int B_W   = 13,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic [2:0]       cur_mode,
    input  logic [A_W-1:0]   cur_a,
    input  logic [B_W-1:0]   cur_b,
    input  logic             cur_byp,
    input  logic [2:0]       new_mode,
    input  logic [A_W-1:0]   new_a,
    input  logic [B_W-1:0]   new_b,
    input  logic             new_byp,
    output logic             period_end,
    output logic [LEN_W-1:0] next_len
);
    typedef struct packed {
        logic [B_W-1:0] idx;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [B_W-1:0] beff_cur;
    logic           last_cyc;
    logic           restart;

    function automatic logic [B_W-1:0] b_eff(input logic [B_W-1:0] b);
        b_eff = (b == '0) ? B_W'(1) : b;
    endfunction

    // Length of prescaler cycle number idx within a period
    function automatic logic [LEN_W-1:0] len_of(
        input logic [2:0]     m,
        input logic [A_W-1:0] a,
        input logic [B_W-1:0] b,
        input logic           byp,
        input logic [B_W-1:0] idx
    );
        logic [B_W-1:0] be;
        logic [B_W-1:0] ax;
        logic [B_W-1:0] swal;
        be   = b_eff(b);
        ax   = B_W'(a);
        swal = byp ? '0 : ((ax > be) ? be : ax);
        if (mode_dual(m) && !byp && (idx < swal)) begin
            len_of = mode_base(m) + LEN_W'(1);
        end else begin
            len_of = mode_base(m);
        end
    endfunction

    assign beff_cur   = b_eff(cur_b);
    assign last_cyc   = cur_byp || (st_q.idx == beff_cur - B_W'(1));
    assign period_end = wrap && last_cyc;
    assign restart    = rst || period_end;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.idx = '0;
            next_len = len_of(new_mode, new_a, new_b, new_byp, '0);
        end else begin
            if (wrap) begin
                st_d.idx = st_q.idx + B_W'(1);
            end
            next_len = len_of(cur_mode, cur_a, cur_b, cur_byp, st_q.idx + B_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R9: the cycle index never reaches the effective B count
    p_idx_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.idx < beff_cur);

    // R7: a period boundary restarts the cycle index
    p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (st_q.idx == '0));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     mode_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           bbyp_i,
    output logic           div_o
);
    localparam int L_W = fbdiv_pkg::LEN_W;

    typedef struct packed {
        logic [2:0]     mode;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           byp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic           wrap;
    logic           period_end;
    logic [L_W-1:0] next_len;

    always_comb begin
        cfg_d = cfg_q;
        if (rst || period_end) begin
            cfg_d.mode = mode_i;
            cfg_d.a    = a_i;
            cfg_d.b    = b_i;
            cfg_d.byp  = bbyp_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    fbdiv_presc #(
        .LEN_W (L_W)
    ) u_presc (
        .clk      (clk),
        .rst      (rst),
        .load_len (next_len),
        .wrap     (wrap)
    );

    fbdiv_seq #(
        .A_W   (A_W),
        .B_W   (B_W),
        .LEN_W (L_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .cur_mode   (cfg_q.mode),
        .cur_a      (cfg_q.a),
        .cur_b      (cfg_q.b),
        .cur_byp    (cfg_q.byp),
        .new_mode   (mode_i),
        .new_a      (a_i),
        .new_b      (b_i),
        .new_byp    (bbyp_i),
        .period_end (period_end),
        .next_len   (next_len)
    );

    assign div_o = period_end && !rst;

    // R6: the captured configuration only moves at a period boundary
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(cfg_q));

    // R5: an output pulse always coincides with a prescaler wrap
    p_out_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        div_o |-> wrap);

    // R4: with bypass, every prescaler wrap ends a period
    p_byp_each_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.byp && wrap) |-> div_o);

    // R7: output stays low while reset is held
    p_low_in_reset_r7: assert property (@(posedge clk)
        rst |-> !div_o);

endmodule

// File: tb/fbdiv_top_tb_top.sv
module fbdiv_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd0;
    logic [5:0]  a_i = '0;
    logic [12:0] b_i = 13'd1;
    logic        bbyp_i = 1'b0;
    logic        div_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    int  p1, p2, np;

    always #4 clk = ~clk;

    fbdiv_top dut_i (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .bbyp_i (bbyp_i),
        .div_o  (div_o)
    );

    // {mode, A, B, bypass, expected N}
    localparam int NV = 14;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 6'd0,  13'd5,   1'b0, 8'd5},
        {3'd1, 6'd7,  13'd4,   1'b0, 8'd8},
        {3'd7, 6'd0,  13'd3,   1'b0, 8'd9},
        {3'd2, 6'd1,  13'd3,   1'b0, 8'd7},
        {3'd3, 6'd2,  13'd3,   1'b0, 8'd14},
        {3'd4, 6'd3,  13'd4,   1'b0, 8'd35},
        {3'd5, 6'd0,  13'd2,   1'b0, 8'd32},
        {3'd6, 6'd1,  13'd1,   1'b0, 8'd33},
        {3'd4, 6'd5,  13'd2,   1'b0, 8'd18},
        {3'd3, 6'd3,  13'd0,   1'b0, 8'd5},
        {3'd5, 6'd9,  13'd100, 1'b1, 8'd16},
        {3'd7, 6'd0,  13'd50,  1'b1, 8'd3},
        {3'd0, 6'd0,  13'd1,   1'b0, 8'd1},
        {3'd0, 6'd0,  13'd0,   1'b1, 8'd1}
    };
    localparam string TAGS [NV] = '{
        "R3", "R3", "R1", "R2", "R2", "R2", "R1", "R1",
        "R8", "R9", "R4", "R4", "R5", "R4"
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [5:0] a,
                         input logic [12:0] b, input logic y);
        mode_i = m;
        a_i    = a;
        b_i    = b;
        bbyp_i = y;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Cycle 1 is the first cycle with reset low
    task automatic scan(input int len);
        p1 = 0; p2 = 0; np = 0;
        for (int k = 1; k <= len; k++) begin
            #1;
            if (div_o) begin
                np++;
                if (np == 1) p1 = k;
                else if (np == 2) p2 = k;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R7: output low during reset even with an N of one setting
        apply(3'd0, 6'd0, 13'd0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            check(div_o == 1'b0, "R7", "output during reset", div_o, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        scan(3);
        check(np == 3 && p1 == 1, "R5", "pulse every cycle at N=1", np, 3);

        // Table walk: first pulse at N, second at 2N, nothing else
        for (int v = 0; v < NV; v++) begin
            int n;
            n = int'(VEC[v][7:0]);
            apply(VEC[v][30:28], VEC[v][27:22], VEC[v][21:9], VEC[v][8]);
            do_reset();
            scan(2 * n);
            check(p1 == n, TAGS[v], $sformatf("vec %0d first pulse", v), p1, n);
            check(np == 2 && p2 == 2 * n, TAGS[v],
                  $sformatf("vec %0d second pulse", v), p2, 2 * n);
        end

        // R6: mid-period change finishes the old period (14) then runs the new (6)
        apply(3'd3, 6'd2, 13'd3, 1'b0);
        do_reset();
        p1 = 0; p2 = 0; np = 0;
        for (int k = 1; k <= 24; k++) begin
            #1;
            if (div_o) begin
                np++;
                if (np == 1) p1 = k;
                else if (np == 2) p2 = k;
            end
            if (k == 5) apply(3'd1, 6'd0, 13'd3, 1'b0);
            @(negedge clk);
        end
        check(p1 == 14, "R6", "old period kept", p1, 14);
        check(p2 == 20 && np == 2, "R6", "new period after boundary", p2, 20);

        // R7: reset mid-period restarts the count
        apply(3'd4, 6'd3, 13'd4, 1'b0);
        do_reset();
        repeat (20) @(negedge clk);
        do_reset();
        scan(35);
        check(p1 == 35 && np == 1, "R7", "restart after mid-period reset", p1, 35);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule